// File: doc/BRIEF.md
# Dual Supply Monitor Control Register

This block sits between two supply comparators (one watching the analog rail, one watching the digital rail) and a processor. It drives a 2-bit trip-level code to each comparator. It cleans up the comparators' digital outputs and keeps a sticky low-supply flag. It raises an interrupt request when that flag is set and the external interrupt enable is high. Software reaches everything through one 8-bit register on a plain byte write / combinational read bus.

Each comparator input passes through a synchroniser and then a glitch filter. The filter accepts a new level only after it has been sampled for a set number of consecutive cycles. While the monitor is enabled, a low on either filtered comparator sets the flag. Software cannot clear the flag while a rail is low. The flag clears by itself only after both rails have stayed good, with no break, for a qualification window. In the product that window is 250 ms; here it is a parameter counted in clock cycles. A dip during the window throws away the time already counted. The count starts again from zero at the next recovery.

Top module: `supply_guard`

## Requirements
- R1: After reset the register reads 0xDE. Both status bits are 1, the flag is 0, both trip codes are 11 and the enable bit is 0. Both trip outputs drive 2'b11.
- R2: Register bit 7 shows the filtered digital-rail comparator and bit 6 shows the filtered analog-rail comparator. A value of 1 means the rail is above its trip level. Writes to these two bits have no effect.
- R3: A write loads bits 4:3 into the digital trip code and bits 2:1 into the analog trip code. Each code appears unchanged on its output from the cycle after the write: 00 = highest level, 01, 10, 11 = lowest level.
- R4: While enable (bit 0) is 1 and either status bit is 0, the flag (bit 5) is 1 from the next cycle on.
- R5: A write of 0 to the flag is ignored while either status bit is 0. A write of 1 to the flag always sets it.
- R6: While enabled, with both status bits 1 and the flag set, the flag clears by itself after exactly HOLD_CYCLES consecutive such cycles, and not earlier.
- R7: If either status bit drops to 0 during the qualification window, the count is discarded. The full HOLD_CYCLES are counted again from the next time both bits return to 1.
- R8: A comparator input change reaches its status bit only after it has been present for FILT_LEN consecutive synchronised samples. With two synchroniser stages, the status bit changes SYNC_STAGES + FILT_LEN clock edges after the input. A pulse shorter than FILT_LEN cycles never reaches the status bit.
- R9: While enable is 0, comparator state never sets the flag and the qualification count is held at zero, so a set flag stays set. Software writes to the flag still take effect.
- R10: `irq` is 1 exactly when the flag is 1 and `intEnable` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data (combinational) |
| cmpAnaIn | input | 1 | Analog-rail comparator output, asynchronous |
| cmpDigIn | input | 1 | Digital-rail comparator output, asynchronous |
| intEnable | input | 1 | External interrupt enable |
| irq | output | 1 | Interrupt request |
| tripAna | output | 2 | Trip level code for the analog-rail comparator |
| tripDig | output | 2 | Trip level code for the digital-rail comparator |

## Verification
The bench builds the block with HOLD_CYCLES = 20, FILT_LEN = 3 and SYNC_STAGES = 2. With these values the qualification window can be measured to the exact cycle many times in a short run, and the filter's acceptance and rejection edges sit only a few cycles apart. All sixteen trip-code pairs are swept. The window is measured from each observed recovery of a status bit: after a plain recovery, after a mid-window dip, and after a software set of the flag.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam logic [7:0] REG_RESET = 8'hDE;

  typedef struct packed {
    logic setFlag;    // comparator low while enabled
    logic writeFlag;  // accepted software write to the flag
    logic clearFlag;  // qualification window finished
    logic runTimer;   // count this cycle, else hold counter at zero
  } sgStrobe_t;
endpackage

// File: rtl/sg_filter.sv
module sg_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic level
);
  localparam int CW = $clog2(FILT_LEN) + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0]          runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  // level follows the synchronised sample only after FILT_LEN agreeing samples
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level  <= 1'b1;
      runCnt <= '0;
    end else if (syncQ[SYNC_STAGES-1] == level) begin
      runCnt <= '0;
    end else if (runCnt == CW'(FILT_LEN - 1)) begin
      level  <= syncQ[SYNC_STAGES-1];
      runCnt <= '0;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sg_control.sv
module sg_control
  import sg_pkg::*;
(
  input  logic      enable,
  input  logic      flag,
  input  logic      lowAny,
  input  logic      wrEn,
  input  logic      wrFlagBit,
  input  logic      timerAtEnd,
  output sgStrobe_t strobe
);
  always_comb begin
    strobe.setFlag   = enable && lowAny;
    strobe.writeFlag = wrEn && !strobe.setFlag && (wrFlagBit || !lowAny);
    strobe.runTimer  = enable && !lowAny && flag;
    strobe.clearFlag = strobe.runTimer && timerAtEnd;
  end
endmodule

// File: rtl/sg_datapath.sv
module sg_datapath
  import sg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  parameter int HOLD_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpAnaIn,
  input  logic       cmpDigIn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  sgStrobe_t  strobe,
  output logic       lowAny,
  output logic       enable,
  output logic       flag,
  output logic       timerAtEnd,
  output logic [1:0] tripAna,
  output logic [1:0] tripDig,
  output logic [7:0] rdData
);
  localparam int TW = $clog2(HOLD_CYCLES + 1);

  logic [1:0]    okLevel;  // [1] digital rail, [0] analog rail
  logic [TW-1:0] holdCnt;

  for (genvar i = 0; i < 2; i++) begin : g_filt
    sg_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (i == 0 ? cmpAnaIn : cmpDigIn),
      .level (okLevel[i])
    );
  end

  assign lowAny     = ~&okLevel;
  assign timerAtEnd = (holdCnt == TW'(HOLD_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tripDig <= REG_RESET[4:3];
      tripAna <= REG_RESET[2:1];
      enable  <= REG_RESET[0];
    end else if (wrEn) begin
      tripDig <= wrData[4:3];
      tripAna <= wrData[2:1];
      enable  <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 flag <= REG_RESET[5];
    else if (strobe.setFlag)   flag <= 1'b1;
    else if (strobe.writeFlag) flag <= wrData[5];
    else if (strobe.clearFlag) flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           holdCnt <= '0;
    else if (!strobe.runTimer || timerAtEnd) holdCnt <= '0;
    else                                 holdCnt <= holdCnt + 1'b1;
  end

  assign rdData = {okLevel[1], okLevel[0], flag, tripDig, tripAna, enable};
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import sg_pkg::*;
#(
  parameter int CLK_HZ      = 50_000_000,
  parameter int HOLD_MS     = 250,
  parameter int HOLD_CYCLES = CLK_HZ / 1000 * HOLD_MS,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       cmpAnaIn,
  input  logic       cmpDigIn,
  input  logic       intEnable,
  output logic       irq,
  output logic [1:0] tripAna,
  output logic [1:0] tripDig
);
  sgStrobe_t strobe;
  logic lowAny, enable, flag, timerAtEnd;

  sg_control u_ctrl (
    .enable     (enable),
    .flag       (flag),
    .lowAny     (lowAny),
    .wrEn       (wrEn),
    .wrFlagBit  (wrData[5]),
    .timerAtEnd (timerAtEnd),
    .strobe     (strobe)
  );

  sg_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .FILT_LEN    (FILT_LEN),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmpAnaIn   (cmpAnaIn),
    .cmpDigIn   (cmpDigIn),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .strobe     (strobe),
    .lowAny     (lowAny),
    .enable     (enable),
    .flag       (flag),
    .timerAtEnd (timerAtEnd),
    .tripAna    (tripAna),
    .tripDig    (tripDig),
    .rdData     (rdData)
  );

  assign irq = flag && intEnable;
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
  parameter int HOLD_CYCLES = 1000
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       intEnable,
  input logic       irq,
  input logic [1:0] tripAna,
  input logic [1:0] tripDig
);
  localparam int TW = $clog2(HOLD_CYCLES + 1);

  logic          qualifying;
  logic [TW-1:0] goodRun;

  assign qualifying = rdData[0] && rdData[7] && rdData[6] && rdData[5];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         goodRun <= '0;
    else if (!qualifying || goodRun == TW'(HOLD_CYCLES - 1)) goodRun <= '0;
    else                                               goodRun <= goodRun + 1'b1;
  end

  p_trip_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (tripDig == $past(wrData[4:3]) && tripAna == $past(wrData[2:1])));

  p_low_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[0] && (!rdData[7] || !rdData[6])) |=> rdData[5]);

  p_no_clear_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[5] && (!rdData[7] || !rdData[6])) |=> rdData[5]);

  p_no_early_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (qualifying && !wrEn && goodRun != TW'(HOLD_CYCLES - 1)) |=> rdData[5]);

  p_exact_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rdData[5]) && !$past(wrEn)) |-> $past(goodRun) == TW'(HOLD_CYCLES - 1));

  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[0] && !wrEn) |=> (rdData[5] == $past(rdData[5])));

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (intEnable && rdData[5]));
endmodule

bind supply_guard sg_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .intEnable (intEnable),
  .irq       (irq),
  .tripAna   (tripAna),
  .tripDig   (tripDig)
);

// File: tb/supply_guard_test.sv
module supply_guard_test;
  localparam int HOLD = 20;
  localparam int FILT = 3;
  localparam int SYNC = 2;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic cmpAnaIn = 1'b1, cmpDigIn = 1'b1, intEnable = 1'b0;
  logic [7:0] rdData;
  logic irq;
  logic [1:0] tripAna, tripDig;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  supply_guard #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC), .FILT_LEN(FILT)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .cmpAnaIn(cmpAnaIn), .cmpDigIn(cmpDigIn), .intEnable(intEnable), .irq(irq),
    .tripAna(tripAna), .tripDig(tripDig)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(logic [7:0] v);
    wrEn = 1'b1; wrData = v;
    step();
    wrEn = 1'b0;
  endtask

  // steps until register bit b equals v; returns steps taken
  task automatic waitBit(int b, logic v, output int n);
    n = 0;
    while (rdData[b] != v && n < 500) begin step(); n++; end
  endtask

  initial begin
    int n;
    logic seenLow;
    step(3);
    rstN = 1'b1;
    step();
    // R1 reset state
    check("R1 reg", rdData, 8'hDE);
    check("R1 trips", {tripDig, tripAna}, 4'hF);
    check("R10 irq idle", irq, 0);

    // R3/R2 sweep of all trip codes, status bits written as 0
    for (int d = 0; d < 4; d++) begin
      for (int a = 0; a < 4; a++) begin
        writeReg({5'(d), 2'(a), 1'b0} & 8'h1E);
        check("R3 tripDig", tripDig, d);
        check("R3 tripAna", tripAna, a);
        check("R2 status ro", rdData[7:6], 2'b11);
      end
    end

    // R8 short pulse rejected (monitor disabled)
    cmpAnaIn = 1'b0; step(FILT - 1); cmpAnaIn = 1'b1;
    seenLow = 1'b0;
    for (int i = 0; i < 12; i++) begin step(); if (!rdData[6]) seenLow = 1'b1; end
    check("R8 short pulse", seenLow, 0);
    // R8 exact acceptance latency
    cmpAnaIn = 1'b0;
    step(SYNC + FILT - 1);
    check("R8 not yet", rdData[6], 1);
    step();
    check("R8 accepted", rdData[6], 0);
    step(10);
    check("R9 no set disabled", rdData[5], 0);
    cmpAnaIn = 1'b1; step(10);
    check("R8 recovered", rdData[6], 1);

    // R4 set on low, R10 gating
    writeReg(8'h01);
    cmpDigIn = 1'b0;
    waitBit(7, 1'b0, n);
    check("R4 same cycle", rdData[5], 0);
    step();
    check("R4 flag set", rdData[5], 1);
    check("R10 irq masked", irq, 0);
    intEnable = 1'b1; step();
    check("R10 irq on", irq, 1);

    // R5 write 0 ignored while low, enabled and disabled
    writeReg(8'h01);
    check("R5 enabled", rdData[5], 1);
    writeReg(8'h00);
    check("R5 disabled", rdData[5], 1);
    writeReg(8'h01);

    // R6 exact window after recovery
    cmpDigIn = 1'b1;
    waitBit(7, 1'b1, n);
    waitBit(5, 1'b0, n);
    check("R6 window", n, HOLD);
    check("R10 irq off", irq, 0);

    // R7 dip mid-window restarts count
    cmpAnaIn = 1'b0;
    waitBit(6, 1'b0, n); step();
    cmpAnaIn = 1'b1;
    waitBit(6, 1'b1, n);
    step(10);
    check("R7 mid window", rdData[5], 1);
    cmpAnaIn = 1'b0; step(FILT + 2); cmpAnaIn = 1'b1;
    waitBit(6, 1'b0, n);
    waitBit(6, 1'b1, n);
    waitBit(5, 1'b0, n);
    check("R7 full restart", n, HOLD);

    // R9 disabled: set flag held, writes still act
    writeReg(8'h20);
    step(2 * HOLD);
    check("R9 held", rdData[5], 1);
    writeReg(8'h00);
    check("R9 write clears", rdData[5], 0);
    cmpDigIn = 1'b0; step(15);
    check("R9 low no set", rdData[5], 0);
    cmpDigIn = 1'b1; step(10);

    // R6/R5 software set while enabled, self clear after window
    writeReg(8'h21);
    check("R5 write one", rdData[5], 1);
    waitBit(5, 1'b0, n);
    check("R6 sw window", n, HOLD);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule